// File: doc/BRIEF.md
# Quantized Step-Duration Clock Generator

This block produces the step clock for a sixteen-step sequencer. Each phase of that clock, high and low alike, lasts a programmable whole number of main-clock periods. The main clock reaches the block as a one-cycle `tick` strobe in the system clock domain, one strobe per main-clock rising edge. A falling edge of `stepClk` moves the sequencer to its next step. The sequencer then presents that step's duration code on `durCode`.

A small down counter holds the remaining length of the current phase. Each tick is counted while the block runs. A tick that finds the count at zero is a borrow. A borrow toggles `stepClk` and parks the counter at its all-ones value. In the next system cycle, the counter is reloaded with the code on `durCode`. If a tick arrives first, it uses the code directly. As a result, code N gives N+1 ticks per phase, and a whole step spans 2(N+1) ticks. Because of the deferred reload, the sequencer can change the code in response to the falling edge, and the new step still gets its own duration.

Top module: `qsc_step_clock`

## Requirements
- R1: A synchronous reset drives `stepClk` and `stepAdvance` low and loads the counter with the `durCode` present during reset. The first low phase after reset therefore lasts that code plus one ticks.
- R2: With code N, each low phase and each high phase of `stepClk` lasts exactly N+1 counted ticks. `stepClk` keeps its level through the first N ticks and inverts on tick N+1.
- R3: The smallest code, 0, gives a phase of 1 tick. The largest code, 15 (all ones), gives a phase of 16 ticks.
- R4: `stepAdvance` is high for exactly the one system cycle that follows a high-to-low transition of `stepClk`. It is low at every other time.
- R5: The code is sampled in the system cycle after a borrow, or at the next tick if one comes in that cycle. A code placed on `durCode` in the cycle after `stepAdvance` rises sets the length of the new step. Code changes at any later point in a phase have no effect on its length.
- R6: While `run` is low, ticks are ignored: `stepClk` and the count hold. After `run` returns high, counting continues from the held count.
- R7: Ticks on consecutive system cycles are each counted, including a tick that coincides with the deferred reload.
- R8: `stepClk` changes only at a clock edge that samples `tick` high with `run` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle strobe per main-clock rising edge |
| run | input | 1 | High to count ticks, low to hold |
| durCode | input | CODE_W (4) | Duration code of the current step; phase length is code plus one |
| stepClk | output | 1 | Quantized step clock; its falling edge advances the sequencer |
| stepAdvance | output | 1 | One-cycle pulse after each falling edge of `stepClk` |

## Verification
`stepClk` and `stepAdvance` are registered at the same edge that samples the borrowing tick. The bench therefore drives each tick from a falling edge and reads both outputs at the following falling edge, with no extra latency. The reload takes effect one system cycle after a borrow, so the bench writes the next step's code at the same falling edge where it sees `stepAdvance`. That is in time for the reload edge, and the bench then counts the new phase. Spurious code changes are made only after the first tick of a phase and are undone before the borrowing tick, so they fall inside the window where R5 says they are ignored.

// File: rtl/qsc_pkg.sv
package qsc_pkg;

  // Strobes from the phase control to the counting datapath.
  typedef struct packed {
    logic useCode;    // a reload is still owed: count from durCode, not the register
    logic decrement;  // counted tick, count not yet zero
    logic wrap;       // counted tick at zero: borrow, park at all ones
    logic loadCode;   // deferred reload in a cycle without a counted tick
  } cntCtrl_t;

endpackage

// File: rtl/qsc_count_path.sv
module qsc_count_path
  import qsc_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] durCode,
  input  cntCtrl_t          ctrl,
  output logic              isZero
);

  localparam logic [CODE_W-1:0] ALL_ONES = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] ONE      = {{(CODE_W-1){1'b0}}, 1'b1};

  logic [CODE_W-1:0] cnt;
  logic [CODE_W-1:0] effCnt;

  // An owed reload is resolved here, so a tick in the reload cycle sees the new code.
  assign effCnt = ctrl.useCode ? durCode : cnt;
  assign isZero = (effCnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= durCode;
    end else if (ctrl.wrap) begin
      cnt <= ALL_ONES;
    end else if (ctrl.decrement) begin
      cnt <= effCnt - ONE;
    end else if (ctrl.loadCode) begin
      cnt <= durCode;
    end
  end

endmodule

// File: rtl/qsc_phase_ctrl.sv
module qsc_phase_ctrl
  import qsc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     run,
  input  logic     isZero,
  output cntCtrl_t ctrl,
  output logic     stepClk,
  output logic     stepAdvance
);

  logic reloadOwed;
  logic counted;

  assign counted = run & tick;

  always_comb begin
    ctrl.useCode   = reloadOwed;
    ctrl.decrement = counted & ~isZero;
    ctrl.wrap      = counted & isZero;
    ctrl.loadCode  = reloadOwed & run & ~tick;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reloadOwed <= 1'b0;
    end else if (counted) begin
      reloadOwed <= isZero;
    end else if (ctrl.loadCode) begin
      reloadOwed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stepClk     <= 1'b0;
      stepAdvance <= 1'b0;
    end else begin
      stepAdvance <= ctrl.wrap & stepClk;
      if (ctrl.wrap) begin
        stepClk <= ~stepClk;
      end
    end
  end

endmodule

// File: rtl/qsc_step_clock.sv
module qsc_step_clock
  import qsc_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              run,
  input  logic [CODE_W-1:0] durCode,
  output logic              stepClk,
  output logic              stepAdvance
);

  cntCtrl_t cntCtrl;
  logic     cntZero;

  qsc_phase_ctrl i_ctrl (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .run         (run),
    .isZero      (cntZero),
    .ctrl        (cntCtrl),
    .stepClk     (stepClk),
    .stepAdvance (stepAdvance)
  );

  qsc_count_path #(.CODE_W(CODE_W)) i_path (
    .clk     (clk),
    .rst     (rst),
    .durCode (durCode),
    .ctrl    (cntCtrl),
    .isZero  (cntZero)
  );

endmodule

// File: rtl/qsc_checker.sv
module qsc_checker #(
  parameter int CODE_W = 4
) (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic run,
  input logic stepClk,
  input logic stepAdvance
);

  localparam int PHASE_MAX = 2 ** CODE_W;
  localparam int CNT_W     = $clog2(PHASE_MAX) + 2;
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(PHASE_MAX);

  logic             lastClk;
  logic [CNT_W-1:0] phaseTicks;

  // Counts ticks since the last level change of stepClk.
  always_ff @(posedge clk) begin
    if (rst) begin
      lastClk    <= 1'b0;
      phaseTicks <= '0;
    end else begin
      lastClk <= stepClk;
      if (stepClk != lastClk) begin
        phaseTicks <= (tick & run) ? CNT_W'(1) : '0;
      end else if (tick & run) begin
        phaseTicks <= phaseTicks + CNT_W'(1);
      end
    end
  end

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (rst)
    phaseTicks <= LIMIT); // R3

  AST_ADV_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    stepAdvance |-> (!stepClk && $past(stepClk))); // R4

  AST_ADV_SINGLE: assert property (@(posedge clk) disable iff (rst)
    stepAdvance |=> !stepAdvance); // R4

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(stepClk)); // R6

  AST_CHANGE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(stepClk)); // R8

endmodule

bind qsc_step_clock qsc_checker #(.CODE_W(CODE_W)) i_chk (.*);

// File: tb/test_qsc_step_clock.sv
module test_qsc_step_clock;

  localparam int CODE_W = 4;

  logic              clk = 1'b0;
  logic              rst;
  logic              tick;
  logic              run;
  logic [CODE_W-1:0] durCode;
  logic              stepClk;
  logic              stepAdvance;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  qsc_step_clock #(.CODE_W(CODE_W)) i_qsc_step_clock (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .run         (run),
    .durCode     (durCode),
    .stepClk     (stepClk),
    .stepAdvance (stepAdvance)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the tick was sampled.
  task automatic tickOnce();
    tick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
  endtask

  function automatic logic [CODE_W-1:0] codeOf(input int i);
    if (i < 16) return CODE_W'((i + 9) % 16);
    return CODE_W'((i * 7) % 16);
  endfunction

  // One full step: low phase then high phase, each code+1 ticks.
  task automatic runStep(input int idx, input int gap, input bit glitch, input bit stopMid);
    logic [CODE_W-1:0] code;
    int len;
    code = codeOf(idx);
    len  = int'(code) + 1;
    for (int ph = 0; ph < 2; ph++) begin
      for (int k = 1; k <= len; k++) begin
        tickOnce();
        if (k < len) begin
          chk(code == 0 ? "R3 hold" : "R2 hold", stepClk, ph[0]);
          chk("R4 no advance", stepAdvance, 1'b0);
        end else begin
          chk((code == 0 || code == 15) ? "R3 toggle" : "R2 toggle", stepClk, ~ph[0]);
          chk("R4 advance on fall", stepAdvance, ph == 1);
          if (ph == 1) durCode = codeOf(idx + 1);  // R5 new step code in reload cycle
        end
        if (glitch && code >= 2 && k == 1) durCode = ~code;  // R5 ignored mid-phase
        if (glitch && code >= 2 && k == len - 1) durCode = code;
        if (stopMid && ph == 0 && k == 1) begin
          run = 1'b0;
          for (int s = 0; s < 4; s++) begin
            tickOnce();
            chk("R6 stopped hold", stepClk, 1'b0);
            chk("R6 stopped no advance", stepAdvance, 1'b0);
          end
          run = 1'b1;
        end
        if (gap > 0) begin
          repeat (gap) @(negedge clk);
          chk("R8 idle hold", stepClk, (k < len) ? ph[0] : ~ph[0]);
        end
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    tick = 1'b0;
    run = 1'b1;
    durCode = codeOf(0);  // R1 code loaded at reset (9 -> 10-tick phase)
    repeat (3) @(negedge clk);
    chk("R1 reset low", stepClk, 1'b0);
    chk("R1 reset no advance", stepAdvance, 1'b0);
    rst = 1'b0;
    @(negedge clk);

    // Sweep every code, gap 0 exercises consecutive ticks (R7).
    for (int i = 0; i < 32; i++) begin
      runStep(i, i % 3, (i % 4) == 1, (i == 5) || (i == 20));
    end

    // Mid-phase reset, then a 3-tick phase from the code held at reset.
    tickOnce();
    durCode = 4'd2;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 mid reset low", stepClk, 1'b0);
    chk("R1 mid reset no advance", stepAdvance, 1'b0);
    tickOnce();
    tickOnce();
    chk("R1 reload hold", stepClk, 1'b0);
    tickOnce();
    chk("R1 reload toggle", stepClk, 1'b1);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule